// File: doc/BRIEF.md
# Vector-Length CSR Read Rewriter

This decode-stage block keeps a tiny cache that names the scalar register currently holding the vector length. The cache is only a 5-bit register index. Every valid 32-bit instruction is examined in two ways. A vector-configuration instruction reloads the cache. A CSR read of the vector-length register, arriving while the cache is non-zero, is replaced in the same cycle by an ordinary scalar move from the cached register. Dependency tracking downstream then sees a plain register-to-register operation, so no CSR hazard logic and no stall are needed.

A vector-configuration instruction is recognised by three fields: opcode `1010111`, funct3 `111` and bit 31 clear. Its destination index is in bits [11:7] and its source index in bits [19:15]. Bits [30:20] carry an immediate that this block ignores. When such an instruction is accepted, a mode input chooses between two actions. With the mode input high, the cache loads the destination index. With it low, the cache is cleared, and a zero cache means the vector length is not mapped to any scalar register. A flush input also clears the cache.

Top module: `vl_csr_rewriter`

## Requirements
- R1: While reset is asserted and afterwards, the cache reads as zero, so a vector-length CSR read that arrives before any configuration instruction leaves the block unchanged with `rewrite_o` low.
- R2: A valid instruction with bits[6:0]=1010111, bits[14:12]=111 and bit31=0 is a configuration instruction. If `vl_in_reg_i` is high and `flush_i` is low, the cache takes its bits[11:7] on the next clock edge.
- R3: A valid configuration instruction with `vl_in_reg_i` low clears the cache on the next clock edge.
- R4: A valid instruction with bits[6:0]=1110011, bits[14:12]=010, bits[19:15]=0 and bits[31:20]=`VL_CSR_ADDR` is a vector-length read. When the cache holds a non-zero index c, that read leaves the block in the same cycle as {12'b0, c, 3'b000, rd, 7'b0010011}. This is an ADDI of c into the original rd with a zero immediate, and `rewrite_o` is high.
- R5: When the cache is zero, no rewrite takes place: a vector-length read passes through unchanged with `rewrite_o` low. This includes the case where a configuration instruction with rd=0 loaded the cache.
- R6: Every other instruction passes through unchanged with `rewrite_o` low. This covers a different CSR address, a non-zero bits[19:15], and other funct3 values. Any instruction that is not a configuration instruction, including a configuration-like word with bit31=1, leaves the cache unchanged.
- R7: `flush_i` clears the cache on the next clock edge and takes priority over a configuration instruction in the same cycle. A rewrite in the flush cycle itself still uses the old cache value.
- R8: With `valid_i` low, the output equals the input, `rewrite_o` is low and the cache keeps its value (unless `flush_i` is high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Pipeline flush; clears the cache |
| valid_i | input | 1 | Qualifies the instruction for cache update and rewrite |
| vl_in_reg_i | input | 1 | Mode: configuration loads rd into the cache when high, clears it when low |
| instr_i | input | 32 | Incoming instruction word |
| instr_o | output | 32 | Instruction word, possibly rewritten |
| rewrite_o | output | 1 | High when `instr_o` is a substituted move |

## Verification
The bench builds the block with the default `VL_CSR_ADDR` of 12'hC20. Its random CSR reads use neighbouring addresses that differ from it in a single bit, which exercises every bit of the address compare. Configuration destinations are drawn over all 32 indices, including zero, so the inactive-cache path appears alongside every possible move source. Flushes land on configuration cycles and on read cycles, which reaches the priority rule and the old-value rewrite.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int CSR_W   = 12;

  localparam logic [6:0] OPC_VCFG   = 7'b1010111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [2:0] F3_VCFG    = 3'b111;
  localparam logic [2:0] F3_CSRRS   = 3'b010;
  localparam logic [2:0] F3_ADDI    = 3'b000;

  typedef struct packed {
    logic             is_cfg;
    logic             is_vl_read;
    logic [REG_W-1:0] rd;
  } vlr_decode_t;
endpackage

// File: rtl/vlr_rst_sync.sv
module vlr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/vlr_classify.sv
module vlr_classify
  import vlr_pkg::*;
#(
  parameter logic [CSR_W-1:0] VL_CSR_ADDR = 12'hC20
) (
  input  logic [INSTR_W-1:0] instr_i,
  output vlr_decode_t        dec_o
);
  logic [6:0]       opc;
  logic [2:0]       f3;
  logic [REG_W-1:0] src;
  logic [CSR_W-1:0] csr;

  always_comb begin
    opc = instr_i[6:0];
    f3  = instr_i[14:12];
    src = instr_i[19:15];
    csr = instr_i[31:20];
    dec_o.rd         = instr_i[11:7];
    dec_o.is_cfg     = (opc == OPC_VCFG) && (f3 == F3_VCFG) && !instr_i[31];
    dec_o.is_vl_read = (opc == OPC_SYSTEM) && (f3 == F3_CSRRS) &&
                       (src == '0) && (csr == VL_CSR_ADDR);
  end
endmodule

// File: rtl/vlr_cache.sv
module vlr_cache
  import vlr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             upd_i,
  input  logic             mode_i,
  input  logic [REG_W-1:0] rd_i,
  output logic [REG_W-1:0] cache_o
);
  logic [REG_W-1:0] cache_q;
  logic [REG_W-1:0] cache_d;
  logic             cache_en;

  always_comb begin
    cache_en = flush_i || upd_i;
    cache_d  = cache_q;
    if (flush_i)     cache_d = '0;
    else if (upd_i)  cache_d = mode_i ? rd_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cache_q <= '0;
    else if (cache_en) cache_q <= cache_d;
  end

  assign cache_o = cache_q;

  assert_load_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && mode_i && !flush_i) |=> (cache_q == $past(rd_i)));

  assert_mode_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !mode_i) |=> (cache_q == '0));

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cache_q == '0));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && !flush_i) |=> $stable(cache_q));
endmodule

// File: rtl/vlr_rewrite.sv
module vlr_rewrite
  import vlr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic               vl_read_i,
  input  logic [REG_W-1:0]   cache_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic               rewrite_o
);
  logic             hit;
  logic [INSTR_W-1:0] mv_word;

  always_comb begin
    hit     = valid_i && vl_read_i && (cache_i != '0);
    mv_word = {{(INSTR_W-20){1'b0}}, cache_i, F3_ADDI, instr_i[11:7], OPC_OPIMM};
    instr_o   = hit ? mv_word : instr_i;
    rewrite_o = hit;
  end

  assert_move_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rewrite_o |-> (instr_o[6:0] == 7'b0010011) && (instr_o[11:7] == instr_i[11:7])
                  && (instr_o[31:20] == '0));

  assert_no_rewrite_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rewrite_o |-> (cache_i != '0) && valid_i);

  assert_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rewrite_o |-> (instr_o == instr_i));
endmodule

// File: rtl/vl_csr_rewriter.sv
module vl_csr_rewriter
  import vlr_pkg::*;
#(
  parameter logic [11:0] VL_CSR_ADDR = 12'hC20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush_i,
  input  logic        valid_i,
  input  logic        vl_in_reg_i,
  input  logic [31:0] instr_i,
  output logic [31:0] instr_o,
  output logic        rewrite_o
);
  logic             rst_sync_n;
  vlr_decode_t      dec;
  logic [REG_W-1:0] cache;

  vlr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  vlr_classify #(.VL_CSR_ADDR(VL_CSR_ADDR)) u_cls (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  vlr_cache u_cache (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .flush_i (flush_i),
    .upd_i   (valid_i && dec.is_cfg),
    .mode_i  (vl_in_reg_i),
    .rd_i    (dec.rd),
    .cache_o (cache)
  );

  vlr_rewrite u_rw (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .valid_i   (valid_i),
    .vl_read_i (dec.is_vl_read),
    .cache_i   (cache),
    .instr_i   (instr_i),
    .instr_o   (instr_o),
    .rewrite_o (rewrite_o)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_sync_n |-> !rewrite_o);
endmodule

// File: tb/vl_csr_rewriter_tb_top.sv
`timescale 1ns/1ps
module vl_csr_rewriter_tb_top;
  localparam logic [11:0] VLA = 12'hC20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i, valid_i, vl_in_reg_i;
  logic [31:0] instr_i;
  logic [31:0] instr_o;
  logic        rewrite_o;

  int checks = 0;
  int errors = 0;
  logic [4:0] model_c = 5'd0;

  always #2.5 clk = ~clk;

  vl_csr_rewriter #(.VL_CSR_ADDR(VLA)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .valid_i(valid_i),
    .vl_in_reg_i(vl_in_reg_i), .instr_i(instr_i),
    .instr_o(instr_o), .rewrite_o(rewrite_o)
  );

  function automatic logic [31:0] mk_cfg(input logic [4:0] rd, input logic [4:0] rs,
                                         input logic [10:0] imm, input logic top);
    return {top, imm, rs, 3'b111, rd, 7'b1010111};
  endfunction

  function automatic logic [31:0] mk_csr(input logic [4:0] rd, input logic [11:0] a,
                                         input logic [4:0] rs, input logic [2:0] f3);
    return {a, rs, f3, rd, 7'b1110011};
  endfunction

  function automatic logic is_cfg(input logic [31:0] w);
    return w[6:0] == 7'b1010111 && w[14:12] == 3'b111 && w[31] == 1'b0;
  endfunction

  function automatic logic is_vlr(input logic [31:0] w);
    return w[6:0] == 7'b1110011 && w[14:12] == 3'b010 && w[19:15] == 5'd0 && w[31:20] == VLA;
  endfunction

  function automatic logic [32:0] expect_out(input logic v, input logic [31:0] w,
                                             input logic [4:0] c);
    if (v && is_vlr(w) && c != 5'd0)
      return {1'b1, 12'd0, c, 3'b000, w[11:7], 7'b0010011};
    return {1'b0, w};
  endfunction

  task automatic step(input logic v, input logic f, input logic m,
                      input logic [31:0] w, input string tag);
    logic [32:0] e;
    @(negedge clk);
    valid_i = v; flush_i = f; vl_in_reg_i = m; instr_i = w;
    #1;
    e = expect_out(v, w, model_c);
    checks++;
    if ({rewrite_o, instr_o} !== e) begin
      errors++;
      $display("FAIL %s: actual flag=%b word=%h expected flag=%b word=%h",
               tag, rewrite_o, instr_o, e[32], e[31:0]);
    end
    @(posedge clk);
    if (f) model_c = 5'd0;
    else if (v && is_cfg(w)) model_c = m ? w[11:7] : 5'd0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; flush_i = 0; valid_i = 0; vl_in_reg_i = 0; instr_i = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    step(1, 0, 1, mk_csr(5'd4, VLA, 5'd0, 3'b010), "R1");
    step(1, 0, 1, mk_cfg(5'd5, 5'd2, 11'h3a, 1'b0), "R2");
    step(1, 0, 1, mk_csr(5'd9, VLA, 5'd0, 3'b010), "R4");
    // literal move encoding for R4: addi x9, x5, 0
    checks++;
    if (!(rewrite_o === 1'b1 && instr_o === 32'h00028493)) begin
      errors++;
      $display("FAIL R4 literal: actual %b %h expected 1 00028493", rewrite_o, instr_o);
    end
    step(1, 0, 1, mk_csr(5'd9, VLA ^ 12'h001, 5'd0, 3'b010), "R6");
    step(1, 0, 1, mk_csr(5'd9, VLA, 5'd3, 3'b010), "R6");
    step(1, 0, 1, mk_csr(5'd9, VLA, 5'd0, 3'b011), "R6");
    step(1, 0, 1, mk_cfg(5'd3, 5'd0, 11'h0, 1'b1), "R6");
    step(1, 0, 1, mk_csr(5'd1, VLA, 5'd0, 3'b010), "R6");
    step(0, 0, 1, mk_cfg(5'd7, 5'd0, 11'h0, 1'b0), "R8");
    step(0, 0, 1, mk_csr(5'd2, VLA, 5'd0, 3'b010), "R8");
    step(1, 0, 1, mk_csr(5'd2, VLA, 5'd0, 3'b010), "R8");
    step(1, 1, 1, mk_csr(5'd8, VLA, 5'd0, 3'b010), "R7");
    step(1, 0, 1, mk_csr(5'd8, VLA, 5'd0, 3'b010), "R7");
    step(1, 0, 1, mk_cfg(5'd12, 5'd0, 11'h0, 1'b0), "R2");
    step(1, 1, 1, mk_cfg(5'd6, 5'd0, 11'h0, 1'b0), "R7");
    step(1, 0, 1, mk_csr(5'd8, VLA, 5'd0, 3'b010), "R7");
    step(1, 0, 1, mk_cfg(5'd0, 5'd0, 11'h0, 1'b0), "R5");
    step(1, 0, 1, mk_csr(5'd8, VLA, 5'd0, 3'b010), "R5");
    step(1, 0, 1, mk_cfg(5'd20, 5'd0, 11'h0, 1'b0), "R2");
    step(1, 0, 0, mk_cfg(5'd21, 5'd0, 11'h0, 1'b0), "R3");
    step(1, 0, 1, mk_csr(5'd8, VLA, 5'd0, 3'b010), "R3");

    for (int i = 0; i < 2000; i++) begin
      int unsigned k = $urandom_range(0, 4);
      logic v = ($urandom_range(0, 9) != 0);
      logic f = ($urandom_range(0, 19) == 0);
      logic m = ($urandom_range(0, 9) < 7);
      logic [4:0] rd = 5'($urandom);
      logic [31:0] w;
      string tag;
      case (k)
        0: begin w = mk_cfg(rd, 5'($urandom), 11'($urandom), 1'b0); tag = "R2"; end
        1: begin
             w = mk_csr(rd, VLA, ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'd0, 3'b010);
             tag = "R4";
           end
        2: begin
             w = mk_csr(rd, VLA ^ (12'd1 << $urandom_range(0, 11)), 5'd0, 3'b010);
             tag = "R6";
           end
        3: begin w = mk_cfg(rd, 5'($urandom), 11'($urandom), 1'b1); tag = "R6"; end
        default: begin w = $urandom; tag = "R6"; end
      endcase
      if (!v) tag = "R8";
      else if (f) tag = "R7";
      step(v, f, m, w, tag);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule